// File: doc/BRIEF.md
# SMBus Control Register Slave

This block is the two-wire slave that sits in front of the control register of a bus-isolation buffer. The buffer has two general-purpose I/O pins. SCL and SDA reach the block as plain inputs. Both lines pass through synchronizers and are sampled on a system clock that runs at least 16 times faster than SCL. SCL may run at up to 400 kHz. The block detects Start, Stop and the address byte. When it acknowledges, it pulls SDA low by raising `sda_oe`, and the pad turns that into an open-drain pull-down.

The master can write one data byte. That byte sets the connect-enable output and the two GPIO output levels. A second data byte in the same transfer loads an 8-bit auxiliary configuration register. The master can also read back a status byte. The upper five bits of that byte are live: the connect bit, the two GPIO output bits and the two synchronized GPIO pin levels. The lowest three bits always read as zero.

The wire protocol has no back-pressure: the block accepts every bit the master clocks. The outputs are plain level signals that change only when a data byte is committed.

Top module: `i2c_ctl_slave`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `connect_en` is 0, `gpio_out` is 2'b11, `aux_cfg` is 8'h00 and `sda_oe` is 0.
- R2: The address byte is sent MSB first. Its bits 7..1 must equal {1,1,`dev_sel`}, and its bit 0 selects read (1) or write (0). On a match the slave pulls SDA low during the ninth SCL pulse. On a mismatch it never drives SDA before the next Start, and no output changes.
- R3: The first data byte of a write transfer is acknowledged. Its bit 7 sets `connect_en` (1 = buses joined), bit 6 sets `gpio_out[1]` and bit 5 sets `gpio_out[0]`. Bits 4..0 are ignored.
- R4: The second data byte of a write transfer is acknowledged and loads all 8 bits of `aux_cfg`. It leaves `connect_en` and `gpio_out` unchanged.
- R5: A third or later data byte in one write transfer is not acknowledged and changes no output.
- R6: A read returns, MSB first, {`connect_en`, `gpio_out[1]`, `gpio_out[0]`, `gpio_pin[1]`, `gpio_pin[0]`, 0, 0, 0}. The pin levels are sampled when the byte is loaded.
- R7: During a read, a master ACK makes the slave send the status byte again. A master NACK makes the slave release SDA and drive nothing until the next Start.
- R8: `sda_oe` changes only while SCL is low.
- R9: A Start seen at any point restarts address reception, and the partly received byte is discarded. A Stop returns the slave to idle with SDA released, and no output changes.
- R10: A committed byte reaches its outputs on the fourth system clock edge after the SCL falling edge that ends the eighth data bit. The outputs hold their value at every other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| dev_sel | input | 5 | Lower five bits of the slave address |
| gpio_pin | input | 2 | Live levels on the two GPIO pins |
| connect_en | output | 1 | 1 joins the card bus to the backplane bus |
| gpio_out | output | 2 | Levels driven to the GPIO output logic |
| aux_cfg | output | 8 | Register loaded by the second data byte |

## Verification
A bit counter that is off by one shifts the sampled address or data by one bit. That error shows up at the ninth SCL pulse of the same byte, as a missing or misplaced ACK, or four cycles later as a wrong output value. A byte-index or direction flag that is set wrong sends data to the wrong register, or makes the slave drive SDA when it should stay silent. The cycle-exact output comparison catches a wrong register within four system clocks of the byte boundary. The line sample taken at every SCL high catches a stray SDA drive within the same bit.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int DATA_W    = 8;
  localparam int SEL_W     = 5;
  localparam int PIN_W     = 2;
  localparam int BITCNT_W  = $clog2(DATA_W) + 1;
  localparam logic [1:0] DEV_PREFIX = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
  import i2c_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [PIN_W-1:0] pin_i,
  output logic             sda_s,
  output logic [PIN_W-1:0] pin_s,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             start_det,
  output logic             stop_det
);
  localparam int W = PIN_W + 2;

  logic [W-1:0] stg [SYNC_STAGES];
  logic [W-1:0] last;
  logic         scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= {pin_i, sda_i, scl_i};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign last  = stg[SYNC_STAGES-1];
  assign scl_s = last[0];
  assign sda_s = last[1];
  assign pin_s = last[W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] AUX_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr1_en,
  input  logic              wr2_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PIN_W-1:0]  pin_s,
  output logic              connect_en,
  output logic [PIN_W-1:0]  gpio_out,
  output logic [DATA_W-1:0] aux_cfg,
  output logic [DATA_W-1:0] rd_byte
);
  localparam int PAD_W = DATA_W - 1 - 2 * PIN_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      connect_en <= 1'b0;
      gpio_out   <= '1;
      aux_cfg    <= AUX_RST;
    end else begin
      if (wr1_en) begin
        // only the top three positions are writable
        connect_en <= wdata[DATA_W-1];
        gpio_out   <= wdata[DATA_W-2 -: PIN_W];
      end
      if (wr2_en) aux_cfg <= wdata;
    end
  end

  assign rd_byte = {connect_en, gpio_out, pin_s, {PAD_W{1'b0}}};
endmodule

// File: rtl/i2c_slave_seq.sv
module i2c_slave_seq
  import i2c_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [SEL_W-1:0]  dev_sel,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr1_en,
  output logic              wr2_en,
  output logic [DATA_W-1:0] wdata
);
  localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(DATA_W);

  slv_state_t          state;
  logic [BITCNT_W-1:0] cnt;
  logic [DATA_W-1:0]   sh, tx;
  logic [1:0]          idx;
  logic                rw, nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      idx    <= '0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
      wr1_en <= 1'b0;
      wr2_en <= 1'b0;
    end else begin
      wr1_en <= 1'b0;
      wr2_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[DATA_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == ST_ADDR) begin
                if (sh[DATA_W-1:1] == {DEV_PREFIX, dev_sel}) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_AACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (idx < 2'd2) begin
                sda_oe <= 1'b1;
                wr1_en <= (idx == 2'd0);
                wr2_en <= (idx == 2'd1);
                state  <= ST_WACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              idx <= '0;
              if (rw) begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[DATA_W-1];
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WDAT;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (idx != 2'd2) idx <= idx + 2'd1;
              state  <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~tx[~cnt[BITCNT_W-2:0]];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[DATA_W-1];
                cnt    <= '0;
                state  <= ST_RDAT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wdata = sh;
endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave
  import i2c_ctl_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] AUX_RST     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [SEL_W-1:0]  dev_sel,
  input  logic [PIN_W-1:0]  gpio_pin,
  output logic              connect_en,
  output logic [PIN_W-1:0]  gpio_out,
  output logic [DATA_W-1:0] aux_cfg
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PIN_W-1:0]  pin_s;
  logic              wr1_en, wr2_en;
  logic [DATA_W-1:0] wdata, rd_byte;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .pin_i(gpio_pin),
    .sda_s(sda_s), .pin_s(pin_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_seq u_seq (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .dev_sel(dev_sel), .rd_byte(rd_byte), .sda_oe(sda_oe),
    .wr1_en(wr1_en), .wr2_en(wr2_en), .wdata(wdata)
  );

  i2c_ctl_regs #(.AUX_RST(AUX_RST)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr1_en(wr1_en), .wr2_en(wr2_en),
    .wdata(wdata), .pin_s(pin_s), .connect_en(connect_en),
    .gpio_out(gpio_out), .aux_cfg(aux_cfg), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/i2c_ctl_slave_chk.sv
module i2c_ctl_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       connect_en,
  input logic [1:0] gpio_out,
  input logic [7:0] aux_cfg,
  input logic       wr1_en,
  input logic       wr2_en
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R8

  AST_CTL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({connect_en, gpio_out}) |-> $past(wr1_en)); // R3

  AST_AUX_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_cfg) |-> $past(wr2_en)); // R4

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr1_en, wr2_en})); // R5

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |=> !wr1_en); // R10
endmodule

bind i2c_ctl_slave i2c_ctl_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .connect_en(connect_en), .gpio_out(gpio_out), .aux_cfg(aux_cfg),
  .wr1_en(wr1_en), .wr2_en(wr2_en)
);

// File: tb/sim_i2c_ctl_slave.sv
module sim_i2c_ctl_slave;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [4:0] sel = 5'b10110;
  logic [1:0] pins = 2'b01;
  logic       sda_oe, connect_en;
  logic [1:0] gpio_out;
  logic [7:0] aux_cfg;
  wire        sda_line = sda_m & ~sda_oe;

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  logic       exp_conn = 1'b0;
  logic [1:0] exp_gpio = 2'b11;
  logic [7:0] exp_aux  = 8'h00;

  always #(CLK_NS/2) clk = ~clk;

  i2c_ctl_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel(sel), .gpio_pin(pins), .connect_en(connect_en),
    .gpio_out(gpio_out), .aux_cfg(aux_cfg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock reference comparison (R10 timing, R3/R4 values)
  initial forever begin
    @(posedge clk); #1;
    if (rst_n && !done) begin
      chk(connect_en == exp_conn, "R10 connect_en", connect_en, exp_conn);
      chk(gpio_out == exp_gpio, "R10 gpio_out", gpio_out, exp_gpio);
      chk(aux_cfg == exp_aux, "R10 aux_cfg", aux_cfg, exp_aux);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic seen);
    wait_clk(4); sda_m = b;
    wait_clk(4); scl_m = 1'b1;
    wait_clk(4); seen = sda_line;
    wait_clk(4); scl_m = 1'b0;
  endtask

  task automatic do_start();
    wait_clk(4); sda_m = 1'b1;
    wait_clk(4); scl_m = 1'b1;
    wait_clk(8); sda_m = 1'b0;
    wait_clk(8); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    wait_clk(4); sda_m = 1'b0;
    wait_clk(4); scl_m = 1'b1;
    wait_clk(8); sda_m = 1'b1;
    wait_clk(8);
  endtask

  // kind: 0 no commit, 1 control byte, 2 auxiliary byte
  task automatic send_byte(input logic [7:0] b, input int kind, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    repeat (4) @(posedge clk);
    if (kind == 1) begin exp_conn = b[7]; exp_gpio = b[6:5]; end
    else if (kind == 2) exp_aux = b;
    put_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] data[$]);
    logic ack;
    bit   hit = (dev == {2'b11, sel});
    do_start();
    send_byte({dev, 1'b0}, 0, ack);
    chk(ack == hit, "R2 address ack", ack, hit);
    foreach (data[i]) begin
      int kind = !hit ? 0 : (i == 0 ? 1 : (i == 1 ? 2 : 0));
      bit want = hit && i < 2;
      send_byte(data[i], kind, ack);
      if (!hit)        chk(ack == 1'b0, "R2 silent after mismatch", ack, 0);
      else if (i == 0) chk(ack == want, "R3 first data ack", ack, want);
      else if (i == 1) chk(ack == want, "R4 second data ack", ack, want);
      else             chk(ack == want, "R5 extra byte nack", ack, want);
    end
    do_stop();
  endtask

  task automatic rd_txn(input int nbytes);
    logic ack, s;
    logic [7:0] got, want;
    do_start();
    send_byte({2'b11, sel, 1'b1}, 0, ack);
    chk(ack == 1'b1, "R2 read address ack", ack, 1);
    for (int k = 0; k < nbytes; k++) begin
      want = {exp_conn, exp_gpio, pins, 3'b000};
      for (int i = 7; i >= 0; i--) begin put_bit(1'b1, s); got[i] = s; end
      if (k == 0) chk(got == want, "R6 status byte", got, want);
      else        chk(got == want, "R7 repeat after master ack", got, want);
      put_bit((k == nbytes - 1) ? 1'b1 : 1'b0, s);
    end
    for (int i = 0; i < 9; i++) begin
      put_bit(1'b1, s);
      chk(s == 1'b1, "R7 released after nack", s, 1);
    end
    do_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, s;
    wait_clk(5);
    chk(connect_en == 1'b0, "R1 reset connect", connect_en, 0);
    chk(gpio_out == 2'b11, "R1 reset gpio", gpio_out, 3);
    chk(aux_cfg == 8'h00, "R1 reset aux", aux_cfg, 0);
    chk(sda_oe == 1'b0, "R1 reset sda", sda_oe, 0);
    rst_n = 1'b1;
    wait_clk(10);
    chk(gpio_out == 2'b11 && connect_en == 1'b0, "R1 after release", {connect_en, gpio_out}, 3);

    wr_txn({2'b11, sel}, '{8'hAF});            // R3 low bits ignored
    pins = 2'b10; wait_clk(8);
    rd_txn(1);                                 // R6
    wr_txn({2'b11, sel}, '{8'h40, 8'h5A});     // R3, R4
    wr_txn({2'b11, sel}, '{8'hE0, 8'h33, 8'hFF}); // R5
    wr_txn(7'b1010110, '{8'h00, 8'h11});       // R2 prefix mismatch
    wr_txn({2'b11, 5'b10111}, '{8'h00});       // R2 low-bit mismatch
    pins = 2'b01; wait_clk(8);
    rd_txn(2);                                 // R7

    // R9: Start in the middle of an address byte
    do_start();
    put_bit(1'b1, s); put_bit(1'b1, s); put_bit(1'b0, s); put_bit(1'b1, s);
    wr_txn({2'b11, sel}, '{8'h9F});
    // R9: Stop in the middle of a data byte leaves outputs alone
    do_start();
    send_byte({2'b11, sel, 1'b0}, 0, ack);
    chk(ack == 1'b1, "R9 address before stop", ack, 1);
    put_bit(1'b0, s); put_bit(1'b1, s); put_bit(1'b1, s);
    do_stop();
    chk(sda_oe == 1'b0, "R9 idle after stop", sda_oe, 0);
    rd_txn(1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule